// File: doc/BRIEF.md
# Interrupt Status Controller with Mixed Edge and Level Semantics

This block keeps the interrupt status of a serial engine. Event sources are grouped into three kinds. Single-cycle event pulses are captured and held: command done, RX last word, cancel done and abort done. Error pulses are captured the same way: command overrun, illegal command, command failure, and read or write errors on the RX and TX FIFOs. Level conditions, the TX and RX watermarks, are latched while they are true and return after an acknowledge if they still hold.

Software acknowledges events through a write-one-to-clear register and selects which captured bits may raise the interrupt line through an enable register. Both registers share one write port, selected by a one-bit address. Status is captured whether or not its enable bit is set. The interrupt line is the OR of the status bits that are enabled.

Top module: `isc_irq_status`

## Requirements
- R1: After reset, `status_o` and `enable_o` are all zero and `irq_o` is low.
- R2: A high `evt_pulse_i[k]` in one cycle sets status bit k (cmd done = bit 0, RX last = bit 1, cancel done = bit 2, abort done = bit 3) at that clock edge. The bit stays set until it is cleared.
- R3: A write with `wr_addr_i`=1 (clear) clears every edge-type status bit whose `wr_data_i` bit is 1. A cleared edge bit stays 0 until a new pulse arrives. Bits written as 0 are unaffected.
- R4: If a pulse arrives in the same cycle as a clear of its bit, the bit ends up set.
- R5: A true `lvl_cond_i[j]` sets status bit 4+j (TX watermark = bit 4, RX watermark = bit 5) at the next edge. The bit stays set after the condition drops until it is cleared.
- R6: Clearing a level bit whose condition is still true makes it read 0 in the cycle after the write and 1 again one cycle later.
- R7: A high `err_evt_i[e]` sets status bit 6+e, with edge semantics (R2 to R4). The bits are, in order: cmd overrun, illegal cmd, cmd failure, RX FIFO read error, RX FIFO write error, TX FIFO read error, TX FIFO write error.
- R8: Status bits are captured regardless of the enable register.
- R9: A write with `wr_addr_i`=0 loads `enable_o` with `wr_data_i`. `irq_o` is high exactly when (`status_o` AND `enable_o`) is non-zero.
- R10: A write to the enable address leaves the status unchanged. A clear write leaves `enable_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse_i | input | 4 | Completion event pulses |
| err_evt_i | input | 7 | Error event pulses |
| lvl_cond_i | input | 2 | Watermark level conditions |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = enable register, 1 = clear register |
| wr_data_i | input | 13 | Write data, one bit per status position |
| status_o | output | 13 | Captured status |
| enable_o | output | 13 | Enable mask read-back |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench uses the default split: 4 pulse events, 2 level conditions and 7 errors, 13 bits in total. This is small enough to sweep every bit position through set, clear, set-versus-clear collision and masked-versus-unmasked interrupt. A long walk driven by a pseudo-random sequence then compares every cycle against a per-bit arithmetic model. That walk reaches overlapping writes, pulses and level changes that the directed sweeps do not combine.

// File: rtl/isc_pkg.sv
package isc_pkg;

  localparam int unsigned ISC_ADDR_ENABLE = 0;
  localparam int unsigned ISC_ADDR_CLEAR  = 1;

  typedef enum logic [1:0] {
    BIT_KIND_EVENT = 2'd0,
    BIT_KIND_LEVEL = 2'd1,
    BIT_KIND_ERROR = 2'd2
  } bit_kind_e;

  // Classify a status position from the group sizes.
  function automatic bit_kind_e isc_kind(input int unsigned idx,
                                         input int unsigned n_evt,
                                         input int unsigned n_lvl);
    if (idx < n_evt)              return BIT_KIND_EVENT;
    else if (idx < n_evt + n_lvl) return BIT_KIND_LEVEL;
    else                          return BIT_KIND_ERROR;
  endfunction

  // Interrupt reduction, kept as a function so the rule has one home.
  function automatic logic isc_irq_any(input logic [63:0] st,
                                       input logic [63:0] en);
    return |(st & en);
  endfunction

endpackage

// File: rtl/isc_edge_cell.sv
module isc_edge_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic st_o
);

  logic st_q;
  logic st_d;

  always_comb begin
    if (set_i)      st_d = 1'b1;
    else if (clr_i) st_d = 1'b0;
    else            st_d = st_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= 1'b0;
    else        st_q <= st_d;
  end

  assign st_o = st_q;

  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> st_o); // R2
  AST_EDGE_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !st_o); // R3
  AST_EDGE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i) |=> st_o); // R4

endmodule

// File: rtl/isc_level_cell.sv
module isc_level_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  input  logic clr_i,
  output logic st_o
);

  logic st_q;
  logic st_d;

  // A clear wins for one edge. A persisting condition sets the bit again on the following edge.
  always_comb begin
    if (clr_i) st_d = 1'b0;
    else       st_d = st_q | cond_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= 1'b0;
    else        st_q <= st_d;
  end

  assign st_o = st_q;

  AST_LEVEL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i && !clr_i) |=> st_o); // R5
  AST_LEVEL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !st_o); // R6

endmodule

// File: rtl/isc_ctrl_regs.sv
module isc_ctrl_regs #(
  parameter int unsigned W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic         wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] clr_vec_o,
  output logic [W-1:0] enable_o
);
  import isc_pkg::*;

  logic         en_we;
  logic         clr_we;
  logic [W-1:0] enable_q;

  assign en_we     = wr_en_i && (wr_addr_i == 1'(ISC_ADDR_ENABLE));
  assign clr_we    = wr_en_i && (wr_addr_i == 1'(ISC_ADDR_CLEAR));
  assign clr_vec_o = clr_we ? wr_data_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)     enable_q <= '0;
    else if (en_we) enable_q <= wr_data_i;
  end

  assign enable_o = enable_q;

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && !wr_addr_i) |=> $stable(enable_o)); // R10
  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_addr_i) |=> (enable_o == $past(wr_data_i))); // R9

endmodule

// File: rtl/isc_irq_status.sv
module isc_irq_status #(
  parameter int unsigned NUM_EVT = 4,
  parameter int unsigned NUM_LVL = 2,
  parameter int unsigned NUM_ERR = 7
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_EVT-1:0]                   evt_pulse_i,
  input  logic [NUM_ERR-1:0]                   err_evt_i,
  input  logic [NUM_LVL-1:0]                   lvl_cond_i,
  input  logic                                 wr_en_i,
  input  logic                                 wr_addr_i,
  input  logic [NUM_EVT+NUM_LVL+NUM_ERR-1:0]   wr_data_i,
  output logic [NUM_EVT+NUM_LVL+NUM_ERR-1:0]   status_o,
  output logic [NUM_EVT+NUM_LVL+NUM_ERR-1:0]   enable_o,
  output logic                                 irq_o
);
  import isc_pkg::*;

  localparam int unsigned W      = NUM_EVT + NUM_LVL + NUM_ERR;
  localparam int unsigned LVL_LO = NUM_EVT;
  localparam int unsigned ERR_LO = NUM_EVT + NUM_LVL;

  logic [W-1:0] clr_vec;
  logic [W-1:0] st_vec;
  logic [W-1:0] en_vec;
  logic [63:0]  st_wide;
  logic [63:0]  en_wide;

  isc_ctrl_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .clr_vec_o (clr_vec),
    .enable_o  (en_vec)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (isc_kind(i, NUM_EVT, NUM_LVL) == BIT_KIND_EVENT) begin : g_evt
      isc_edge_cell u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_pulse_i[i]),
        .clr_i (clr_vec[i]),
        .st_o  (st_vec[i])
      );
    end else if (isc_kind(i, NUM_EVT, NUM_LVL) == BIT_KIND_LEVEL) begin : g_lvl
      isc_level_cell u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond_i (lvl_cond_i[i-LVL_LO]),
        .clr_i  (clr_vec[i]),
        .st_o   (st_vec[i])
      );
    end else begin : g_err
      isc_edge_cell u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (err_evt_i[i-ERR_LO]),
        .clr_i (clr_vec[i]),
        .st_o  (st_vec[i])
      );
      AST_ERR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt_i[i-ERR_LO] |=> status_o[i]); // R7
    end
  end

  assign st_wide  = 64'(st_vec);
  assign en_wide  = 64'(en_vec);
  assign status_o = st_vec;
  assign enable_o = en_vec;
  assign irq_o    = isc_irq_any(st_wide, en_wide);

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_o == '0) |-> !irq_o); // R9
  AST_CAPTURE_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse_i[0] && enable_o[0] == 1'b0) |=> status_o[0]); // R8
  AST_EN_WRITE_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_addr_i && evt_pulse_i == '0 && err_evt_i == '0 &&
     lvl_cond_i == '0) |=> (status_o == $past(status_o))); // R10

endmodule

// File: tb/isc_irq_status_test.sv
module isc_irq_status_test;
  localparam int NE = 4, NL = 2, NR = 7, W = NE + NL + NR;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NE-1:0] evt = '0;
  logic [NR-1:0] err = '0;
  logic [NL-1:0] lvl = '0;
  logic wen = 1'b0, waddr = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] status, enable;
  logic irq;

  int vectors = 0, errors = 0;
  logic [W-1:0] m_st = '0, m_en = '0;

  always #2 clk = ~clk;

  isc_irq_status uut (
    .clk(clk), .rst_n(rst_n), .evt_pulse_i(evt), .err_evt_i(err),
    .lvl_cond_i(lvl), .wr_en_i(wen), .wr_addr_i(waddr), .wr_data_i(wdata),
    .status_o(status), .enable_o(enable), .irq_o(irq));

  function automatic bit is_lvl(input int i);
    return (i >= NE) && (i < NE + NL);
  endfunction

  task automatic compare(input string tag);
    logic exp_irq;
    exp_irq = (m_st & m_en) != '0;
    vectors++;
    if (status !== m_st || enable !== m_en || irq !== exp_irq) begin
      errors++;
      $display("FAIL %s: status=%h en=%h irq=%b expected status=%h en=%h irq=%b",
               tag, status, enable, irq, m_st, m_en, exp_irq);
    end
  endtask

  // Apply one cycle of stimulus, advance the model, check after the edge.
  task automatic step(input logic [NE-1:0] e, input logic [NR-1:0] r,
                      input logic [NL-1:0] l, input logic we, input logic a,
                      input logic [W-1:0] d, input string tag);
    logic [W-1:0] setv, clr, nxt;
    evt = e; err = r; lvl = l; wen = we; waddr = a; wdata = d;
    setv = {r, l, e};
    clr  = (we && a) ? d : '0;
    for (int i = 0; i < W; i++) begin
      if (is_lvl(i)) nxt[i] = clr[i] ? 1'b0 : (m_st[i] | setv[i]);
      else           nxt[i] = setv[i] | (m_st[i] & ~clr[i]);
    end
    @(posedge clk);
    #1;
    m_st = nxt;
    if (we && !a) m_en = d;
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step('0, '0, '0, 1'b0, 1'b0, '0, tag);
  endtask

  // Raise bit b with its own source for one cycle.
  task automatic raise(input int b, input string tag);
    logic [W-1:0] v;
    v = '0; v[b] = 1'b1;
    step(v[NE-1:0], v[W-1:NE+NL], v[NE+NL-1:NE], 1'b0, 1'b0, '0, tag);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    #1;
    compare("R1 in reset");
    rst_n = 1'b1;
    idle("R1 after reset");

    // Per-bit sweep: capture, hold, selective clear, collision.
    for (int b = 0; b < W; b++) begin
      logic [W-1:0] one;
      one = '0; one[b] = 1'b1;
      raise(b, (b >= NE + NL) ? "R7 capture" : (is_lvl(b) ? "R5 latch" : "R2 capture"));
      idle("R2 R5 hold");
      step('0, '0, '0, 1'b1, 1'b1, ~one, "R3 zero bits ignored");
      step('0, '0, '0, 1'b1, 1'b1, one, "R3 R6 clear");
      idle("R3 stays clear");
      if (!is_lvl(b)) begin
        logic [W-1:0] v;
        v = one;
        step(v[NE-1:0], v[W-1:NE+NL], '0, 1'b1, 1'b1, one, "R4 set beats clear");
        step('0, '0, '0, 1'b1, 1'b1, one, "R3 clear again");
      end else begin
        logic [NL-1:0] lv;
        lv = '0; lv[b-NE] = 1'b1;
        step('0, '0, lv, 1'b0, 1'b0, '0, "R5 level set");
        step('0, '0, lv, 1'b1, 1'b1, one, "R6 clear while true");
        step('0, '0, lv, 1'b0, 1'b0, '0, "R6 re-asserts");
        step('0, '0, '0, 1'b1, 1'b1, one, "R6 final clear");
      end
    end

    // Masking sweep: status captured with enable off, irq follows enable.
    step('1, '1, '1, 1'b0, 1'b0, '0, "R8 capture unmasked");
    for (int b = 0; b < W; b++) begin
      logic [W-1:0] one;
      one = '0; one[b] = 1'b1;
      step('0, '0, '0, 1'b1, 1'b0, one, "R9 R10 enable single");
      step('0, '0, '0, 1'b1, 1'b1, one, "R9 cleared enabled bit");
      step('0, '0, '0, 1'b1, 1'b0, ~one, "R9 other bits");
    end
    step('0, '0, '0, 1'b1, 1'b0, '0, "R9 disable all");

    // Pseudo-random walk.
    lf = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      logic [NE-1:0] e; logic [NR-1:0] r; logic [NL-1:0] l;
      logic we, a; logic [W-1:0] d;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      e = (lf[3:0] == 4'h0) ? lf[7:4] : '0;
      r = (lf[6:4] == 3'h1) ? lf[15:9] : '0;
      l = lf[12:11];
      we = lf[2]; a = lf[8];
      d = {lf[12:0]} ^ {lf[15:3]};
      step(e, r, l, we, a, d, "R9 R10 walk");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule